// File: doc/BRIEF.md
# SD Command and Response Sequencer

This block sends one card command, made of a 6-bit index and a 32-bit argument, to a card-side command port. It then collects the response bytes the card returns into a response FIFO of 16-bit entries, which the processor reads one entry at a time. A response timer guards each command, and the block can pass control to a separate data-transfer engine once the response has arrived. Serial command-line bit timing and CRC generation belong to the card-side port. That port answers each request with a byte count and a flat byte vector.

A command can be launched in two ways. Software writes the command-control word while the card clock is running. Or it writes the word while the clock is stopped and starts the clock later, which issues the held command. The control word picks whether a response is expected, whether a data phase follows, the direction of that data phase, and whether a deferred clock start may launch the held command.

Top module: `sd_cmd_seq`

## Requirements
- R1: After reset, `card_req`, `stat_clk_on`, `stat_tout`, `stat_end_cmd`, `end_cmd_irq`, `data_start` and `data_write` are 0, and `rsp_rdata` reads 0.
- R2: A `cmdat_we` pulse while the clock status is on and no command is in flight clears `stat_tout`, `stat_end_cmd` and `end_cmd_irq`, and leaves `stat_clk_on` unchanged. `card_req` is high from the next cycle, with `card_idx`/`card_arg` holding the `cmd_index`/`cmd_arg` values sampled at the write.
- R3: A `cmdat_we` pulse while the clock is off only holds the command as pending. A later `clk_start` pulse launches it, unless bit 10 of the stored control word (deferred-start inhibit) is 1, in which case `card_req` stays low.
- R4: When control-word bits 1:0 (response type) are 0, the acknowledged command completes with success whatever byte count the card returns. The FIFO then reads all zero.
- R5: On a successful completion with a nonzero response type, FIFO entry i holds response byte 2i in bits 7:0 and byte 2i+1 in bits 15:8. Byte k is taken from `card_rsp_data[8k+7:8k]`, and any byte whose position is not below `card_rsp_len` reads 0. `stat_end_cmd` and `end_cmd_irq` both rise.
- R6: If the card acknowledges a command with a nonzero response type and a byte count of 0, the block sets `stat_tout` and `end_cmd_irq`, leaves `stat_end_cmd` at 0, and does not start a data phase.
- R7: If no acknowledge arrives, the request ends after `rsp_tout`×256 cycles plus one. The outcome is the same as R6, and the FIFO is cleared.
- R8: Each `rsp_rd` pulse advances the read index to the next entry. After 9 reads the index stays at its end and `rsp_rdata` reads 0. The index returns to entry 0 when a new command starts.
- R9: When control-word bit 2 (data enable) is 1 and the command succeeds, `data_start` is high for exactly the one cycle after completion. `data_write` then equals control-word bit 3 (1 = write to card).
- R10: A `cmdat_we` pulse while `card_req` is high is ignored. The command in flight keeps its control word, and the status is not cleared.
- R11: `clk_start` sets `stat_clk_on` and `clk_stop` clears it; when both arrive in the same cycle, stop wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdat_we | input | 1 | Write strobe for the command-control word |
| cmdat_wdata | input | 14 | Control word: [1:0] response type, [2] data enable, [3] data direction, [10] deferred-start inhibit |
| clk_start | input | 1 | Start-clock pulse |
| clk_stop | input | 1 | Stop-clock pulse |
| cmd_index | input | 6 | Command index sampled at launch |
| cmd_arg | input | 32 | Command argument sampled at launch |
| rsp_tout | input | 7 | Response timeout in units of 256 cycles |
| card_req | output | 1 | Command request to the card port, high while waiting |
| card_idx | output | 6 | Command index presented with the request |
| card_arg | output | 32 | Argument presented with the request |
| card_ack | input | 1 | Card port acknowledge carrying the response |
| card_rsp_len | input | 5 | Number of response bytes returned |
| card_rsp_data | input | 144 | Response bytes, byte k at bits 8k+7:8k |
| rsp_rd | input | 1 | Response FIFO read strobe |
| rsp_rdata | output | 16 | Response entry at the current read index |
| stat_clk_on | output | 1 | Clock-enabled status |
| stat_tout | output | 1 | Response timeout status |
| stat_end_cmd | output | 1 | End-of-command-with-response status |
| end_cmd_irq | output | 1 | End-of-command request |
| data_start | output | 1 | One-cycle launch pulse for the data engine |
| data_write | output | 1 | Direction for the data engine, 1 = write to card |

## Verification
On every cycle, the assertions check the following. `card_idx` and `card_arg` stay steady while a request is open. A launch never happens without the clock or a clock start. The inhibit bit blocks a deferred start. An acknowledge always raises the end-of-command request. A timeout never coincides with a data launch. The read index holds once it reaches its end. The response byte packing, the zero fill past the byte count, the exact timer length, and the resetting of the read index between commands can only be shown by the bench scenarios, which compare whole FIFO contents and status words against values derived from the requirements.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

    localparam int CTRL_W    = 14;
    localparam int CMD_IDX_W = 6;
    localparam int CMD_ARG_W = 32;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic       inhibit_defer;
        logic       write_dir;
        logic       data_en;
        logic [1:0] rsp_type;
    } ctrl_word_t;

    typedef struct packed {
        logic tout;
        logic end_cmd;
        logic irq;
    } cmd_flags_t;

    function automatic ctrl_word_t decode_ctrl(input logic [CTRL_W-1:0] w);
        ctrl_word_t c;
        c.rsp_type      = w[1:0];
        c.data_en       = w[2];
        c.write_dir     = w[3];
        c.inhibit_defer = w[10];
        return c;
    endfunction

    function automatic logic expects_rsp(input ctrl_word_t c);
        return c.rsp_type != 2'd0;
    endfunction

endpackage

// File: rtl/sd_cmd_start_ctl.sv
module sd_cmd_start_ctl (
    input  logic clk,
    input  logic rst,
    input  logic ctrl_we,
    input  logic clk_start,
    input  logic clk_stop,
    input  logic seq_idle,
    input  logic inhibit_q,
    output logic clk_on,
    output logic accept_wr,
    output logic launch
);
    logic pending_q;

    assign accept_wr = ctrl_we & seq_idle;
    assign launch    = seq_idle & ((accept_wr & clk_on) |
                                   (clk_start & pending_q & ~inhibit_q & ~accept_wr));

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_on    <= 1'b0;
            pending_q <= 1'b0;
        end else begin
            if (clk_stop)
                clk_on <= 1'b0;
            else if (clk_start)
                clk_on <= 1'b1;
            if (launch)
                pending_q <= 1'b0;
            else if (accept_wr)
                pending_q <= 1'b1;
        end
    end

    p_start_needs_clock_r3 : assert property (@(posedge clk) disable iff (rst)
        launch |-> (clk_on || clk_start));

    p_inhibit_blocks_r3 : assert property (@(posedge clk) disable iff (rst)
        (clk_start && inhibit_q && !(ctrl_we && clk_on)) |-> !launch);

endmodule

// File: rtl/sd_cmd_timer.sv
module sd_cmd_timer #(
    parameter int TOUT_W     = 7,
    parameter int TOUT_SHIFT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [TOUT_W-1:0] tout_val,
    input  logic              run,
    output logic              expired
);
    localparam int CNT_W = TOUT_W + TOUT_SHIFT;

    logic [CNT_W-1:0] cnt_q;

    assign expired = run && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= {tout_val, {TOUT_SHIFT{1'b0}}};
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    p_no_early_expiry_r7 : assert property (@(posedge clk) disable iff (rst)
        (load && tout_val != '0) |=> !expired);

endmodule

// File: rtl/sd_rsp_fifo.sv
module sd_rsp_fifo #(
    parameter int ENTRIES = 9,
    parameter int LEN_W   = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rewind,
    input  logic                  fill,
    input  logic [LEN_W-1:0]      fill_len,
    input  logic [ENTRIES*16-1:0] fill_bytes,
    input  logic                  rd,
    output logic [15:0]           rdata
);
    localparam int IDX_W = $clog2(ENTRIES + 1);

    logic [15:0]      mem_q [ENTRIES];
    logic [IDX_W-1:0] rd_idx_q;

    function automatic logic [7:0] pick_byte(input logic [ENTRIES*16-1:0] b,
                                             input logic [LEN_W-1:0] n, input int k);
        if (k < int'(n))
            return b[8*k +: 8];
        return 8'h00;
    endfunction

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                mem_q[e] <= '0;
            else if (fill)
                mem_q[e] <= {pick_byte(fill_bytes, fill_len, 2*e + 1),
                             pick_byte(fill_bytes, fill_len, 2*e)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || rewind)
            rd_idx_q <= '0;
        else if (rd && rd_idx_q != IDX_W'(ENTRIES))
            rd_idx_q <= rd_idx_q + 1'b1;
    end

    always_comb begin
        rdata = '0;
        for (int e = 0; e < ENTRIES; e++)
            if (rd_idx_q == IDX_W'(e))
                rdata = mem_q[e];
    end

    p_idx_holds_at_end_r8 : assert property (@(posedge clk) disable iff (rst)
        (rd_idx_q == IDX_W'(ENTRIES) && rd && !rewind) |=> rd_idx_q == IDX_W'(ENTRIES));

endmodule

// File: rtl/sd_cmd_seq.sv
module sd_cmd_seq
    import sd_cmd_pkg::*;
#(
    parameter int RSP_ENTRIES = 9,
    parameter int TOUT_W      = 7,
    parameter int TOUT_SHIFT  = 8,
    localparam int RSP_BITS   = RSP_ENTRIES * 16,
    localparam int LEN_W      = $clog2(RSP_ENTRIES * 2 + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmdat_we,
    input  logic [CTRL_W-1:0]    cmdat_wdata,
    input  logic                 clk_start,
    input  logic                 clk_stop,
    input  logic [CMD_IDX_W-1:0] cmd_index,
    input  logic [CMD_ARG_W-1:0] cmd_arg,
    input  logic [TOUT_W-1:0]    rsp_tout,
    output logic                 card_req,
    output logic [CMD_IDX_W-1:0] card_idx,
    output logic [CMD_ARG_W-1:0] card_arg,
    input  logic                 card_ack,
    input  logic [LEN_W-1:0]     card_rsp_len,
    input  logic [RSP_BITS-1:0]  card_rsp_data,
    input  logic                 rsp_rd,
    output logic [15:0]          rsp_rdata,
    output logic                 stat_clk_on,
    output logic                 stat_tout,
    output logic                 stat_end_cmd,
    output logic                 end_cmd_irq,
    output logic                 data_start,
    output logic                 data_write
);
    seq_state_e state_q;
    ctrl_word_t ctrl_q;
    cmd_flags_t flags_q;
    logic       accept_wr, launch, expired;
    logic       finish, ok_finish, bad_finish;
    logic [LEN_W-1:0] fill_len;

    sd_cmd_start_ctl u_start (
        .clk       (clk),
        .rst       (rst),
        .ctrl_we   (cmdat_we),
        .clk_start (clk_start),
        .clk_stop  (clk_stop),
        .seq_idle  (state_q == SEQ_IDLE),
        .inhibit_q (ctrl_q.inhibit_defer),
        .clk_on    (stat_clk_on),
        .accept_wr (accept_wr),
        .launch    (launch)
    );

    sd_cmd_timer #(.TOUT_W(TOUT_W), .TOUT_SHIFT(TOUT_SHIFT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (launch),
        .tout_val (rsp_tout),
        .run      (state_q == SEQ_WAIT && !card_ack),
        .expired  (expired)
    );

    assign card_req   = (state_q == SEQ_WAIT);
    assign finish     = card_req && (card_ack || expired);
    assign bad_finish = finish && (expired ||
                        (expects_rsp(ctrl_q) && card_rsp_len == '0));
    assign ok_finish  = finish && !bad_finish;
    assign fill_len   = (ok_finish && expects_rsp(ctrl_q)) ? card_rsp_len : '0;

    sd_rsp_fifo #(.ENTRIES(RSP_ENTRIES), .LEN_W(LEN_W)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .rewind     (launch),
        .fill       (finish),
        .fill_len   (fill_len),
        .fill_bytes (card_rsp_data),
        .rd         (rsp_rd),
        .rdata      (rsp_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SEQ_IDLE;
            ctrl_q     <= '0;
            flags_q    <= '0;
            card_idx   <= '0;
            card_arg   <= '0;
            data_start <= 1'b0;
            data_write <= 1'b0;
        end else begin
            data_start <= 1'b0;
            if (accept_wr) begin
                ctrl_q  <= decode_ctrl(cmdat_wdata);
                flags_q <= '0;
            end
            if (launch) begin
                state_q  <= SEQ_WAIT;
                card_idx <= cmd_index;
                card_arg <= cmd_arg;
            end else if (finish) begin
                state_q     <= SEQ_IDLE;
                flags_q.irq <= 1'b1;
                if (bad_finish) begin
                    flags_q.tout <= 1'b1;
                end else begin
                    flags_q.end_cmd <= 1'b1;
                    if (ctrl_q.data_en) begin
                        data_start <= 1'b1;
                        data_write <= ctrl_q.write_dir;
                    end
                end
            end
        end
    end

    assign stat_tout    = flags_q.tout;
    assign stat_end_cmd = flags_q.end_cmd;
    assign end_cmd_irq  = flags_q.irq;

    p_req_args_stable_r2 : assert property (@(posedge clk) disable iff (rst)
        (card_req && $past(card_req)) |-> ($stable(card_idx) && $stable(card_arg)));

    p_end_irq_on_ack_r5 : assert property (@(posedge clk) disable iff (rst)
        (card_req && card_ack) |=> end_cmd_irq);

    p_tout_no_data_r6 : assert property (@(posedge clk) disable iff (rst)
        $rose(stat_tout) |-> !data_start);

    p_busy_write_ignored_r10 : assert property (@(posedge clk) disable iff (rst)
        (card_req && cmdat_we && !card_ack && !expired) |=> (card_req && $stable(flags_q)));

endmodule

// File: tb/sd_cmd_seq_bench.sv
module sd_cmd_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 9;
    localparam int RBITS      = ENTRIES * 16;

    logic              clk = 1'b0;
    logic              rst;
    logic              cmdat_we, clk_start, clk_stop, card_ack, rsp_rd;
    logic [13:0]       cmdat_wdata;
    logic [5:0]        cmd_index, card_idx;
    logic [31:0]       cmd_arg, card_arg;
    logic [6:0]        rsp_tout;
    logic              card_req;
    logic [4:0]        card_rsp_len;
    logic [RBITS-1:0]  card_rsp_data;
    logic [15:0]       rsp_rdata;
    logic stat_clk_on, stat_tout, stat_end_cmd, end_cmd_irq, data_start, data_write;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sd_cmd_seq u_sd_cmd_seq (
        .clk(clk), .rst(rst), .cmdat_we(cmdat_we), .cmdat_wdata(cmdat_wdata),
        .clk_start(clk_start), .clk_stop(clk_stop), .cmd_index(cmd_index),
        .cmd_arg(cmd_arg), .rsp_tout(rsp_tout), .card_req(card_req),
        .card_idx(card_idx), .card_arg(card_arg), .card_ack(card_ack),
        .card_rsp_len(card_rsp_len), .card_rsp_data(card_rsp_data),
        .rsp_rd(rsp_rd), .rsp_rdata(rsp_rdata), .stat_clk_on(stat_clk_on),
        .stat_tout(stat_tout), .stat_end_cmd(stat_end_cmd),
        .end_cmd_irq(end_cmd_irq), .data_start(data_start), .data_write(data_write)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_entry(input logic [RBITS-1:0] d,
                                              input int n, input int i);
        logic [7:0] lo, hi;
        lo = (2*i < n)     ? d[16*i +: 8]     : 8'h00;
        hi = (2*i + 1 < n) ? d[16*i + 8 +: 8] : 8'h00;
        return {hi, lo};
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_ctrl(input logic [13:0] w, input logic [5:0] idx, input logic [31:0] a);
        cmdat_wdata = w; cmd_index = idx; cmd_arg = a; cmdat_we = 1'b1;
        cyc(1);
        cmdat_we = 1'b0;
    endtask

    task automatic pulse_start();
        clk_start = 1'b1; cyc(1); clk_start = 1'b0;
    endtask

    task automatic pulse_stop();
        clk_stop = 1'b1; cyc(1); clk_stop = 1'b0;
    endtask

    task automatic ack(input int n, input logic [RBITS-1:0] d);
        card_rsp_len = 5'(n); card_rsp_data = d; card_ack = 1'b1;
        cyc(1);
        card_ack = 1'b0;
    endtask

    task automatic read_all(input string tag, input logic [RBITS-1:0] d, input int n);
        for (int i = 0; i < ENTRIES + 2; i++) begin
            chk(tag, rsp_rdata, (i < ENTRIES) ? exp_entry(d, n, i) : 16'h0);
            rsp_rd = 1'b1; cyc(1); rsp_rd = 1'b0;
        end
    endtask

    function automatic logic [RBITS-1:0] rand_bytes();
        logic [RBITS-1:0] d = '0;
        for (int k = 0; k < 5; k++)
            d[32*k +: 32] = $urandom();
        return d;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [RBITS-1:0] d;
        logic [RBITS-1:0] d2;
        void'($urandom(32'd1234));
        rst = 1'b1; cmdat_we = 0; clk_start = 0; clk_stop = 0; card_ack = 0; rsp_rd = 0;
        cmdat_wdata = 0; cmd_index = 0; cmd_arg = 0; rsp_tout = 7'd2;
        card_rsp_len = 0; card_rsp_data = '0;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        chk("R1 outputs", {card_req, stat_clk_on, stat_tout, stat_end_cmd, end_cmd_irq,
                           data_start, data_write}, 0);
        chk("R1 rdata", rsp_rdata, 0);

        // R3 / R11 write with clock off stays pending, clk_start launches
        write_ctrl(14'h0001, 6'd17, 32'hCAFE_0001);
        cyc(2);
        chk("R3 no req with clock off", card_req, 0);
        pulse_start();
        chk("R11 clock on", stat_clk_on, 1);
        chk("R3 deferred launch", card_req, 1);
        chk("R2 index latched", card_idx, 17);
        chk("R2 arg latched", card_arg, 32'hCAFE_0001);
        d = rand_bytes();
        ack(6, d);
        chk("R5 end status and irq", {stat_end_cmd, end_cmd_irq, stat_tout}, 3'b110);
        read_all("R5 packing len6", d, 6);
        read_all("R8 saturate after end", d, 0);

        // R2 status cleared on write, clock kept
        write_ctrl(14'h0000, 6'd3, 32'h1234_5678);
        chk("R2 status cleared", {stat_end_cmd, end_cmd_irq, stat_tout, stat_clk_on}, 4'b0001);
        chk("R2 req", card_req, 1);
        chk("R2 arg", card_arg, 32'h1234_5678);
        // R10 write during busy ignored (type 1 would expect response)
        write_ctrl(14'h0001, 6'd9, 32'h0);
        chk("R10 still busy", card_req, 1);
        chk("R10 index kept", card_idx, 3);
        ack(0, rand_bytes());
        // R4 type 0 with zero length still succeeds
        chk("R4 success no response", {stat_end_cmd, stat_tout}, 2'b10);
        read_all("R4 fifo zero", '0, 0);

        // R6 expected response but zero bytes
        write_ctrl(14'h0005, 6'd2, 32'h0);
        ack(0, rand_bytes());
        chk("R6 tout flags", {stat_tout, stat_end_cmd, end_cmd_irq}, 3'b101);
        chk("R6 no data start", data_start, 0);

        // R9 data handoff, write direction
        write_ctrl(14'h000D, 6'd24, 32'h0);
        d = rand_bytes();
        ack(4, d);
        chk("R9 data start", data_start, 1);
        chk("R9 direction write", data_write, 1);
        cyc(1);
        chk("R9 single pulse", data_start, 0);
        // R8 rewind on new launch
        rsp_rd = 1'b1; cyc(3); rsp_rd = 1'b0;
        write_ctrl(14'h0006, 6'd17, 32'h0);
        d2 = rand_bytes();
        ack(18, d2);
        chk("R9 direction read", data_write, 0);
        chk("R8 rewind entry0", rsp_rdata, exp_entry(d2, 18, 0));
        read_all("R5 full length", d2, 18);

        // R7 timer expiry
        rsp_tout = 7'd1;
        write_ctrl(14'h0002, 6'd1, 32'h0);
        cyc(200);
        chk("R7 still waiting", card_req, 1);
        cyc(100);
        chk("R7 expired", {card_req, stat_tout, stat_end_cmd, end_cmd_irq}, 4'b0101);
        read_all("R7 fifo cleared", '0, 0);
        rsp_tout = 7'd2;

        // R3 inhibit bit blocks deferred start; R11 stop wins
        clk_start = 1'b1; clk_stop = 1'b1; cyc(1); clk_start = 0; clk_stop = 0;
        chk("R11 stop wins", stat_clk_on, 0);
        write_ctrl(14'h0401, 6'd5, 32'h0);
        pulse_start();
        chk("R3 inhibit blocks", card_req, 0);
        write_ctrl(14'h0001, 6'd5, 32'h0);
        chk("R2 direct launch", card_req, 1);
        ack(2, 144'hBEEF);
        chk("R5 short", rsp_rdata, 16'hBEEF);

        // randomized commands
        for (int t = 0; t < 40; t++) begin
            logic [1:0] ty;
            int n;
            logic de;
            logic dir;
            ty = 2'($urandom() % 4);
            n = int'($urandom() % 19);
            de = 1'($urandom() % 2);
            dir = 1'($urandom() % 2);
            d = rand_bytes();
            write_ctrl({10'h0, dir, de, ty}, 6'($urandom()), $urandom());
            cyc(int'($urandom() % 4));
            ack(n, d);
            if (ty != 0 && n == 0) begin
                chk("R6 random tout", {stat_tout, stat_end_cmd, data_start}, 3'b100);
                read_all("R6 random fifo", '0, 0);
            end else begin
                chk("R5 random status", {stat_tout, stat_end_cmd, end_cmd_irq}, 3'b011);
                chk("R9 random start", data_start, de);
                read_all("R5 random fifo", d, (ty == 0) ? 0 : n);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule